// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames into system memory through a circular ring of descriptors that software prepares. Each descriptor occupies 16 bytes: a status word at offset 0, a control word at offset 4 holding the buffer size in bits [10:0] and an end-of-ring flag in bit 31, and the buffer start address at offset 8. When the first byte of a frame arrives, the block fetches the current descriptor. If the descriptor belongs to hardware, the bytes are packed into 32-bit words and written into the buffer. When the frame ends, the block writes a status word back to the descriptor. That write clears the ownership bit and hands the descriptor to software. The block then steps to the next descriptor.

Software arms a descriptor by writing only bit 31 (hardware-owned) into its status word. It marks the last descriptor with the end-of-ring flag and loads the ring start address through a load pulse. A frame that meets a descriptor software still owns is drained and discarded, and a no-buffer status bit is raised. A frame-done status bit is raised once the write-back is complete. Both status bits are sticky and maskable, and together they drive a single interrupt line.

The memory port is a plain single-cycle port: a read returns data in the cycle after it is issued, and a write completes in the cycle it is issued. The byte stream uses a valid/ready pair, and the block holds ready low while it fetches a descriptor or writes back a status word.

Top module: `rx_ring_writer`

## Requirements
- R1: When a frame's first byte is offered while the block is idle, the block reads the current descriptor's words at offsets 0, 4 and 8 in consecutive cycles. The offset-4 read is skipped if the status word shows software ownership. `in_ready` stays low until the fetch is done, and no memory read is issued while `in_ready` is high.
- R2: If bit 31 of the fetched status word is 0, the whole frame is accepted and discarded. No memory write is made, status bit 1 (no buffer) is set, and the ring pointer does not move.
- R3: Frame byte k is stored at buffer address (base with its low 2 bits cleared) + k, in byte lane k mod 4 of a 32-bit word write. A word is written with its byte enables in the cycle that completes it.
- R4: At most min(control bits [10:0], 1600) bytes are stored, and nothing is written beyond that limit. A limit of 0 stores nothing.
- R5: After the last data write, exactly one full-word write goes to descriptor offset 0. Its fields are:
  - bit 31: 0 (ownership returned to software)
  - bit 30: receive error, taken from `in_err[0]` at the last byte
  - bit 29: CRC error, taken from `in_err[1]` at the last byte
  - bit 28: length above 1518
  - bit 27: length below 64
  - bit 26: odd nibble, taken from `in_err[2]` at the last byte
  - bit 25: multicast, equal to bit 0 of the first byte
  - bits [10:0]: the full received length, saturating at 2047, even when the stored bytes were cut short
- R6: After a write-back, the pointer moves to the descriptor 16 bytes on. If bit 31 of the control word was set, it returns to the ring base instead.
- R7: A `ring_load` pulse sets both the ring base and the current pointer to `ring_base` with its low 4 bits forced to 0.
- R8: Status bit 0 (frame done) is set in the cycle after the write-back. Status bits stay set until a 1 is written to the matching `int_clear` bit. `irq` is high whenever a set status bit has its `int_mask` bit set.
- R9: Out of reset the block is idle. `in_ready`, `irq`, the status bits and `mem_en` are 0, and the pointer and ring base are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Ring start address |
| ring_load | input | 1 | Loads base and pointer from ring_base |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 3 | Error tags sampled with the last byte: [0] receive, [1] CRC, [2] odd nibble |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| int_mask | input | 2 | Interrupt mask: [0] done, [1] no buffer |
| int_clear | input | 2 | Write-one-to-clear for status bits |
| int_status | output | 2 | Sticky status: [0] done, [1] no buffer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the following properties:
- A write-back is one full-word write to a 16-byte aligned address with the ownership bit cleared.
- The frame-done bit only rises right after a write-back.
- A descriptor's control read is always followed by its address read.
- No read overlaps byte streaming.
- Every data write coincides with an accepted byte.

Only the bench scenarios can show the values themselves:
- the packed status fields
- the stored byte contents and the truncation boundary
- the return to the ring base after the flagged descriptor
- a dropped frame leaving the pointer in place
- the effect of the mask on `irq`

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW        = 16,
  parameter int LW        = 11,
  parameter int BUF_MAX   = 1600,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_FRAME = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          ring_load,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [2:0]    in_err,
  output logic          in_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic [1:0]    int_mask,
  input  logic [1:0]    int_clear,
  output logic [1:0]    int_status,
  output logic          irq
);
  localparam logic [LW-1:0] LIM_MAX = LW'(BUF_MAX);
  localparam logic [LW-1:0] LEN_TOP = {LW{1'b1}};
  localparam int            PADW    = 25 - LW;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_RECV, S_DROP, S_WB} st_t;

  st_t           st;
  logic [AW-1:0] ptr, base_q, bufa;
  logic          eor;
  logic [LW-1:0] limit, cnt;
  logic [31:0]   wdat;
  logic [3:0]    wbe;
  logic [2:0]    err_q;
  logic          mc_q;
  logic [1:0]    stat;

  logic          wb_now, acc, keep, close_w, owned;
  logic [1:0]    lane;
  logic [31:0]   wd_n;
  logic [3:0]    be_n;
  logic [LW-1:0] cnt_n, size_f;
  logic [31:0]   wb_word;

  assign wb_now   = (st == S_WB);
  assign in_ready = (st == S_RECV) || (st == S_DROP);
  assign acc      = in_valid && in_ready;
  assign lane     = cnt[1:0];
  assign keep     = cnt < limit;
  assign close_w  = keep && (lane == 2'd3 || in_last || cnt == limit - LW'(1));
  assign owned    = mem_rdata[31];
  assign size_f   = mem_rdata[LW-1:0];
  assign cnt_n    = (cnt == LEN_TOP) ? cnt : cnt + LW'(1);
  assign be_n     = wbe | (4'b0001 << lane);
  assign irq      = |(stat & int_mask);
  assign int_status = stat;

  always_comb begin
    wd_n = wdat;
    wd_n[8*lane +: 8] = in_data;
  end

  assign wb_word = {1'b0, err_q[0], err_q[1], (cnt > LW'(MAX_FRAME)), (cnt < LW'(MIN_FRAME)),
                    err_q[2], mc_q, {PADW{1'b0}}, cnt};

  logic unused_rdata;
  assign unused_rdata = ^{mem_rdata[30:LW], mem_rdata[1:0]};

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr;
    mem_be    = 4'h0;
    mem_wdata = 32'h0;
    if (wb_now) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_be    = 4'hF;
      mem_wdata = wb_word;
    end else begin
      case (st)
        S_RD0: mem_en = 1'b1;
        S_RD1: begin mem_en = owned; mem_addr = ptr + AW'(4); end
        S_RD2: begin mem_en = 1'b1;  mem_addr = ptr + AW'(8); end
        S_RECV: begin
          mem_en    = acc && close_w;
          mem_we    = 1'b1;
          mem_addr  = bufa + AW'({cnt[LW-1:2], 2'b00});
          mem_be    = be_n;
          mem_wdata = wd_n;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      base_q <= '0;
      bufa   <= '0;
      eor    <= 1'b0;
      limit  <= '0;
      cnt    <= '0;
      wdat   <= '0;
      wbe    <= '0;
      err_q  <= '0;
      mc_q   <= 1'b0;
      stat   <= '0;
    end else begin
      stat <= (stat & ~int_clear) | {(st == S_RD1) && !owned, wb_now};
      case (st)
        S_IDLE: if (in_valid) st <= S_RD0;
        S_RD0:  st <= S_RD1;
        S_RD1:  st <= owned ? S_RD2 : S_DROP;
        S_RD2: begin
          eor   <= mem_rdata[31];
          limit <= (size_f > LIM_MAX) ? LIM_MAX : size_f;
          st    <= S_RD3;
        end
        S_RD3: begin
          bufa <= {mem_rdata[AW-1:2], 2'b00};
          cnt  <= '0;
          wbe  <= '0;
          st   <= S_RECV;
        end
        S_RECV: if (acc) begin
          cnt <= cnt_n;
          if (cnt == '0) mc_q <= in_data[0];
          if (keep) begin
            wdat <= wd_n;
            wbe  <= close_w ? 4'h0 : be_n;
          end
          if (in_last) begin
            err_q <= in_err;
            st    <= S_WB;
          end
        end
        S_DROP: if (acc && in_last) st <= S_IDLE;
        S_WB: begin
          ptr <= eor ? base_q : ptr + AW'(16);
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (ring_load) begin
        base_q <= {ring_base[AW-1:4], 4'h0};
        ptr    <= {ring_base[AW-1:4], 4'h0};
      end
    end
  end
endmodule

module rx_ring_writer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic [1:0]    int_status,
  input logic          wb_now
);
  a_r1_ctl_then_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && mem_addr[3:0] == 4'h4) |=>
      (mem_en && !mem_we && mem_addr == $past(mem_addr) + AW'(4)));

  a_r1_no_read_stream: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !(mem_en && !mem_we));

  a_r3_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !wb_now) |-> (in_valid && in_ready && mem_be != 4'h0));

  a_r5_wb_form: assert property (@(posedge clk) disable iff (!rst_n)
    wb_now |-> (mem_en && mem_we && mem_be == 4'hF && !mem_wdata[31] && mem_addr[3:0] == 4'h0));

  a_r5_single_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_now |=> !wb_now);

  a_r8_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_status[0]) |-> $past(wb_now));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .int_status(int_status), .wb_now(wb_now)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = '0;
  logic          ring_load = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]    in_data = '0;
  logic [2:0]    in_err = '0;
  logic          in_ready, mem_en, mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [1:0]    int_mask = 2'b00, int_clear = 2'b00, int_status;

  rx_ring_writer #(.AW(AW)) i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_load(ring_load),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .int_mask(int_mask), .int_clear(int_clear), .int_status(int_status), .irq(irq)
  );

  logic [31:0]   mem [0:1023];
  logic          sw_we = 1'b0;
  logic [9:0]    sw_a = '0;
  logic [31:0]   sw_d = '0;
  logic [AW-1:0] rd0 = '0, rd1 = '0, rd2 = '0;
  int            nwr = 0;

  always @(posedge clk) begin
    if (sw_we) mem[sw_a] <= sw_d;
    else if (mem_en && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_en && !mem_we) begin
      mem_rdata <= mem[mem_addr[11:2]];
      rd2 <= rd1; rd1 <= rd0; rd0 <= mem_addr;
    end
    if (mem_en && mem_we) nwr <= nwr + 1;
  end

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [AW-1:0] a, input logic [31:0] d);
    sw_we = 1'b1; sw_a = a[11:2]; sw_d = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic arm(input logic [AW-1:0] da, input int size, input bit eor, input logic [AW-1:0] ba);
    for (int w = 0; w < 64; w++) sw_write(ba + AW'(4*w), 32'hA5A5_A5A5);
    sw_write(da + AW'(4), {eor, 20'd0, 11'(size)});
    sw_write(da + AW'(8), {16'd0, ba});
    sw_write(da, 32'h8000_0000);
  endtask

  function automatic logic [7:0] pat(input int k, input logic [7:0] first, input int seed);
    return (k == 0) ? first : 8'((k + seed*7) & 255);
  endfunction

  function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  task automatic send_frame(input int len, input logic [7:0] first, input logic [2:0] err, input int seed);
    for (int k = 0; k < len; k++) begin
      in_valid = 1'b1;
      in_data  = pat(k, first, seed);
      in_last  = (k == len - 1);
      in_err   = (k == len - 1) ? err : 3'b000;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; in_err = 3'b000;
  endtask

  task automatic wait_bit(input int b);
    for (int i = 0; i < 20 && !int_status[b]; i++) @(negedge clk);
  endtask

  task automatic clear_all;
    int_clear = 2'b11;
    @(negedge clk);
    int_clear = 2'b00;
  endtask

  // {len[65:54], first[53:46], err[45:43], size[42:32], expected status[31:0]}
  localparam logic [65:0] TBL [0:8] = '{
    {12'd64,   8'h00, 3'b000, 11'd256, 32'h0000_0040},
    {12'd70,   8'h01, 3'b000, 11'd256, 32'h0200_0046},
    {12'd10,   8'h02, 3'b000, 11'd256, 32'h0800_000A},
    {12'd66,   8'h00, 3'b001, 11'd256, 32'h4000_0042},
    {12'd65,   8'h00, 3'b010, 11'd256, 32'h2000_0041},
    {12'd67,   8'h03, 3'b100, 11'd256, 32'h0600_0043},
    {12'd64,   8'h00, 3'b000, 11'd7,   32'h0000_0040},
    {12'd1519, 8'h00, 3'b000, 11'd256, 32'h1000_05EF},
    {12'd1,    8'h01, 3'b000, 11'd0,   32'h0A00_0001}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] da, ba;
    int lim, bad, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 in_ready", 32'(in_ready), 0);
    check("R9 irq", 32'(irq), 0);
    check("R9 status", 32'(int_status), 0);
    check("R9 mem_en", 32'(mem_en), 0);

    ring_base = 16'h0100; ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
    int_mask = 2'b01;

    for (int row = 0; row < 9; row++) begin
      int len, size;
      logic [7:0] first;
      logic [2:0] err;
      logic [31:0] exp;
      len = int'(TBL[row][65:54]); first = TBL[row][53:46];
      err = TBL[row][45:43]; size = int'(TBL[row][42:32]); exp = TBL[row][31:0];
      da = AW'(16'h0100 + 16*(row % 4));
      ba = AW'(16'h0400 + 256*(row % 4));
      arm(da, size, (row % 4) == 3, ba);
      send_frame(len, first, err, row);
      wait_bit(0);
      check("R8 done bit", 32'(int_status[0]), 1);
      check("R8 irq on done", 32'(irq), 1);
      check("R5 R6 status word at expected descriptor", mem[da[11:2]], exp);
      check("R1 fetch offset 0", 32'(rd2), 32'(da));
      check("R1 fetch offset 4", 32'(rd1), 32'(da + AW'(4)));
      check("R1 fetch offset 8", 32'(rd0), 32'(da + AW'(8)));
      lim = len;
      if (size < lim) lim = size;
      if (lim > 256) lim = 256;
      bad = 0;
      for (int k = 0; k < lim; k++)
        if (mbyte(ba + AW'(k)) !== pat(k, first, row)) bad++;
      check("R3 stored bytes", 32'(bad), 0);
      if (lim < 256) check("R4 byte past limit untouched", 32'(mbyte(ba + AW'(lim))), 32'hA5);
      clear_all();
      check("R8 status cleared", 32'(int_status), 0);
    end

    da = 16'h0110;
    arm(da, 256, 1'b0, 16'h0500);
    sw_write(da, 32'h0);
    w0 = nwr;
    send_frame(20, 8'h00, 3'b000, 9);
    wait_bit(1);
    check("R2 no-buffer bit", 32'(int_status[1]), 1);
    check("R2 no memory write", 32'(nwr), 32'(w0));
    check("R2 status word untouched", mem[da[11:2]], 0);
    check("R8 masked no-buffer keeps irq low", 32'(irq), 0);
    int_mask = 2'b10;
    @(negedge clk);
    check("R8 unmasked no-buffer raises irq", 32'(irq), 1);
    clear_all();
    int_mask = 2'b01;
    arm(da, 256, 1'b0, 16'h0500);
    send_frame(64, 8'h00, 3'b000, 10);
    wait_bit(0);
    check("R2 pointer unchanged after drop", mem[da[11:2]], 32'h0000_0040);
    clear_all();

    ring_base = 16'h020F; ring_load = 1'b1;
    @(negedge clk);
    ring_load = 1'b0;
    arm(16'h0200, 256, 1'b1, 16'h0400);
    send_frame(64, 8'h00, 3'b000, 11);
    wait_bit(0);
    check("R7 loaded base used", mem[16'h0200 >> 2], 32'h0000_0040);
    check("R7 fetch at aligned base", 32'(rd2), 32'h0200);
    clear_all();
    arm(16'h0200, 256, 1'b1, 16'h0400);
    send_frame(65, 8'h00, 3'b000, 12);
    wait_bit(0);
    check("R6 end-of-ring returns to base", mem[16'h0200 >> 2], 32'h0000_0041);
    clear_all();

    int_mask = 2'b00;
    arm(16'h0200, 256, 1'b1, 16'h0400);
    send_frame(64, 8'h00, 3'b000, 13);
    wait_bit(0);
    check("R8 done set while masked", 32'(int_status[0]), 1);
    check("R8 masked irq low", 32'(irq), 0);
    clear_all();
    check("R8 cleared", 32'(int_status), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule